// File: doc/BRIEF.md
# Extended-Data-Out DRAM Output Driver Controller

This block is the control logic for the data output path of an extended-data-out DRAM. It watches the four active-low strobes: row strobe `ras_n`, column strobe `cas_n`, write enable `we_n` and output enable `oe_n`. It also receives the read word from the array. From these it drives a data output register and a tri-state enable for the data pins. The strobes are sampled with a system clock, and edges are found by comparing each strobe with its value at the previous clock edge.

A cycle opens when the row strobe falls with the column strobe high. The internal I/O path is open while the column strobe is low inside such a cycle. When the row strobe rises with the drivers on, the output word is held, which gives the extended-data-out behaviour. A row-strobe fall while the column strobe is already low is a refresh cycle with the column strobe first, and it keeps the output as it was. Early writes, late writes, read-modify-write, page-mode reads, refresh with the row strobe only, and cycles with the column strobe only are all sorted out from the same few pieces of state.

Top module: `edo_dout_ctrl`

## Requirements
- R1: When the row strobe rises while `dq_oe` is 1 and `cas_n` is low, the output word is held and driven until `cas_n` rises. If `dq_oe` was 0 at that rise, the pins stay high-impedance after it, even if `oe_n` then goes low.
- R2: In an open cycle, a low `cas_n` with `we_n` high and `oe_n` low drives `rd_data` on `dq_out` with `dq_oe`=1. A high `cas_n` gives `dq_oe`=0.
- R3: A fall of `cas_n` while `ras_n` is high, with no held word, leaves `dq_oe` at 0.
- R4: `oe_n` high forces `dq_oe` to 0 and does not change the held word. Driving resumes with the same word when `oe_n` returns low.
- R5: `we_n` low while `cas_n` is low forces `dq_oe` to 0.
- R6: If `we_n` is low when `cas_n` falls (early write), the pins stay high-impedance for the whole column-strobe low period, even if `we_n` rises. In a late write, the pins follow `oe_n` until `we_n` falls.
- R7: Several column-strobe pulses in one row cycle each present the current `rd_data`. A refresh with the row strobe only keeps `dq_oe` at 0.
- R8: A fall of `ras_n` while `cas_n` is already low (refresh with the column strobe first) leaves `dq_oe` and `dq_out` as they were in the previous cycle. This holds through the following rise of the row strobe.
- R9: Reset gives `dq_oe`=0 and `dq_out`=0. Outputs are registered: a change sampled at one clock edge shows on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DATA_W | Word read from the array |
| dq_out | output | DATA_W | Registered output word |
| dq_oe | output | 1 | Registered tri-state enable, 1 = drive pins |

## Verification
The main output decision is tried with a plain read, page-mode reads with a different word in each column pulse, and reads where the row strobe rises before the column strobe. The last case shows the hold behaviour and separates it from an ordinary end of cycle. Write patterns follow: `we_n` low before the column fall versus after it, which tells early write apart from late write and read-modify-write. Refresh with the row strobe only, column-only pulses and refresh with the column strobe first check that the cycle-opening rule treats them differently. Each refresh is started from both a driving state and a high-impedance state. `oe_n` is toggled over a held word to show that it masks the drivers but never changes the stored data.

// File: rtl/edo_out_pkg.sv
package edo_out_pkg;

  // positions of the strobes inside the packed edge-detector vector
  localparam int unsigned SIDX_RAS = 0;
  localparam int unsigned SIDX_CAS = 1;
  localparam int unsigned NUM_EDGE_STROBES = 2;

  // active-low strobe went from high to low
  function automatic logic f_fell(input logic prev_n, input logic cur_n);
    return prev_n & ~cur_n;
  endfunction

  // active-low strobe went from low to high
  function automatic logic f_rose(input logic prev_n, input logic cur_n);
    return ~prev_n & cur_n;
  endfunction

  // data is taken from the array: path open, not an early write, write idle
  function automatic logic f_load(input logic path, input logic ewr, input logic we_n);
    return path & ~ewr & we_n;
  endfunction

  // drivers wanted before the output-enable mask
  function automatic logic f_want(input logic path, input logic ewr,
                                  input logic hold, input logic we_n);
    return ((path & ~ewr) | hold) & we_n;
  endfunction

endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb_n,
  output logic [N-1:0] fell,
  output logic [N-1:0] rose
);
  import edo_out_pkg::*;

  logic [N-1:0] prev_n;

  for (genvar i = 0; i < N; i++) begin : g_strb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n[i] <= 1'b1;
      else        prev_n[i] <= strb_n[i];
    end
    assign fell[i] = f_fell(prev_n[i], strb_n[i]);
    assign rose[i] = f_rose(prev_n[i], strb_n[i]);
  end

endmodule

// File: rtl/edo_cycle_track.sv
module edo_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ras_fell,
  input  logic ras_rose,
  input  logic cas_fell,
  input  logic cas_rose,
  input  logic drv_q,
  output logic path_nx,
  output logic ewr_nx,
  output logic hold_nx,
  output logic hold_q,
  output logic cbr_q
);

  logic open_q, open_nx;
  logic ewr_q;
  logic cbr_nx;

  // row cycle state: normal cycle or refresh with column strobe first
  always_comb begin
    open_nx = open_q;
    cbr_nx  = cbr_q;
    if (ras_fell) begin
      open_nx = cas_n;
      cbr_nx  = ~cas_n;
    end else if (ras_rose) begin
      open_nx = 1'b0;
      cbr_nx  = 1'b0;
    end
  end

  assign path_nx = open_nx & ~cas_n;

  // early write flag, decided at the column fall
  always_comb begin
    ewr_nx = ewr_q;
    if (cas_rose || ras_rose)     ewr_nx = 1'b0;
    else if (cas_fell && open_nx) ewr_nx = ~we_n;
  end

  // extended-data-out hold: set when the row closes with drivers on
  always_comb begin
    hold_nx = hold_q;
    if (cas_rose || cas_n)                 hold_nx = 1'b0;
    else if (ras_rose && drv_q)            hold_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cbr_q  <= 1'b0;
      ewr_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      open_q <= open_nx;
      cbr_q  <= cbr_nx;
      ewr_q  <= ewr_nx;
      hold_q <= hold_nx;
    end
  end

endmodule

// File: rtl/edo_out_stage.sv
module edo_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              path_nx,
  input  logic              ewr_nx,
  input  logic              hold_nx,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  import edo_out_pkg::*;

  logic load_w, want_w;

  assign load_w = f_load(path_nx, ewr_nx, we_n);
  assign want_w = f_want(path_nx, ewr_nx, hold_nx, we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (load_w) dq_out <= rd_data;
      dq_oe <= want_w & ~oe_n;
    end
  end

endmodule

// File: rtl/edo_dout_ctrl.sv
module edo_dout_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  import edo_out_pkg::*;

  localparam int unsigned NE = NUM_EDGE_STROBES;

  logic [NE-1:0] strb_n, fell_v, rose_v;
  logic ras_fell, ras_rose, cas_fell, cas_rose;
  logic path_nx, ewr_nx, hold_nx, hold_q, cbr_q;

  always_comb begin
    strb_n           = '1;
    strb_n[SIDX_RAS] = ras_n;
    strb_n[SIDX_CAS] = cas_n;
  end

  edo_strobe_edges #(.N(NE)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb_n (strb_n),
    .fell   (fell_v),
    .rose   (rose_v)
  );

  assign ras_fell = fell_v[SIDX_RAS];
  assign ras_rose = rose_v[SIDX_RAS];
  assign cas_fell = fell_v[SIDX_CAS];
  assign cas_rose = rose_v[SIDX_CAS];

  edo_cycle_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ras_fell (ras_fell),
    .ras_rose (ras_rose),
    .cas_fell (cas_fell),
    .cas_rose (cas_rose),
    .drv_q    (dq_oe),
    .path_nx  (path_nx),
    .ewr_nx   (ewr_nx),
    .hold_nx  (hold_nx),
    .hold_q   (hold_q),
    .cbr_q    (cbr_q)
  );

  edo_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .path_nx (path_nx),
    .ewr_nx  (ewr_nx),
    .hold_nx (hold_nx),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .rd_data (rd_data),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

endmodule

// File: rtl/edo_dout_ctrl_chk.sv
module edo_dout_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              hold_q,
  input logic              cbr_q
);

  // R9: outputs are high-impedance while reset is held
  p_reset_hiz_r9: assert property (@(posedge clk) !rst_n |=> !dq_oe);

  // R4: output enable high masks the drivers
  p_oe_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_oe);

  // R4: a held word is never altered while held
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> $stable(dq_out));

  // R5: write enable low with column strobe low disables the drivers
  p_we_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !cas_n) |=> !dq_oe);

  // R2: column strobe high disables the drivers
  p_cas_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dq_oe);

  // R3: with the row strobe high and nothing held, the drivers stay off
  p_ras_high_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && $past(ras_n) && !hold_q) |=> !dq_oe);

  // R8: entering a column-first refresh keeps the driver state
  p_cbr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cbr_q) && !oe_n && we_n && $past(!oe_n && we_n)) |-> $stable(dq_oe));

endmodule

bind edo_dout_ctrl edo_dout_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ras_n  (ras_n),
  .cas_n  (cas_n),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .dq_out (dq_out),
  .dq_oe  (dq_oe),
  .hold_q (hold_q),
  .cbr_q  (cbr_q)
);

// File: tb/edo_dout_ctrl_tb.sv
module edo_dout_ctrl_tb;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [W-1:0] rd_data = '0;
  logic [W-1:0] dq_out;
  logic dq_oe;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  edo_dout_ctrl #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .rd_data(rd_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // drive one sampled step and wait until the registered result is visible
  task automatic step(input logic r, input logic c, input logic w,
                      input logic o, input logic [W-1:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; rd_data = d;
    @(negedge clk);
  endtask

  task automatic chk_oe(input string req, input logic exp);
    n_chk++;
    if (dq_oe !== exp) begin
      n_err++;
      $display("FAIL %s: dq_oe=%b expected %b", req, dq_oe, exp);
    end
  endtask

  task automatic chk_drv(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      n_err++;
      $display("FAIL %s: dq_oe=%b dq_out=%h expected 1/%h", req, dq_oe, dq_out, exp);
    end
  endtask

  task automatic idle();
    step(1, 1, 1, 0, 8'h00);
    step(1, 1, 1, 0, 8'h00);
  endtask

  task automatic t_reset();
    n_chk++;
    if (dq_oe !== 1'b0 || dq_out !== '0) begin
      n_err++;
      $display("FAIL R9: dq_oe=%b dq_out=%h expected 0/00", dq_oe, dq_out);
    end
  endtask

  task automatic t_read();
    idle();
    step(0, 1, 1, 0, 8'h11); chk_oe("R2 row open only", 0);
    step(0, 0, 1, 0, 8'hA5); chk_drv("R2 read drive / R9 latency", 8'hA5);
    step(0, 0, 1, 1, 8'hA5); chk_oe("R4 oe high", 0);
    step(0, 0, 1, 0, 8'hA5); chk_drv("R4 oe low again", 8'hA5);
    step(0, 1, 1, 0, 8'hA5); chk_oe("R2 cas high", 0);
    step(1, 1, 1, 0, 8'hA5); chk_oe("R2 end", 0);
  endtask

  task automatic t_hold();
    idle();
    step(0, 1, 1, 0, 8'h00);
    step(0, 0, 1, 0, 8'h3C); chk_drv("R1 read", 8'h3C);
    step(1, 0, 1, 0, 8'h3C); chk_drv("R1 hold on ras rise", 8'h3C);
    step(1, 0, 1, 0, 8'hFF); chk_drv("R1 hold ignores rd_data", 8'h3C);
    step(1, 0, 1, 1, 8'hFF); chk_oe("R4 oe masks hold", 0);
    step(1, 0, 1, 0, 8'hEE); chk_drv("R4 held word unchanged", 8'h3C);
    // column-first refresh from a driving state
    step(0, 0, 1, 0, 8'h77); chk_drv("R8 cbr keeps drive", 8'h3C);
    step(0, 0, 1, 0, 8'h66); chk_drv("R8 cbr keeps word", 8'h3C);
    step(1, 0, 1, 0, 8'h55); chk_drv("R8 cbr ras rise", 8'h3C);
    step(1, 1, 1, 0, 8'h55); chk_oe("R1 cas rise ends hold", 0);
  endtask

  task automatic t_no_hold();
    idle();
    step(0, 1, 1, 1, 8'h00);
    step(0, 0, 1, 1, 8'h42); chk_oe("R1 oe high in read", 0);
    step(1, 0, 1, 1, 8'h42);
    step(1, 0, 1, 0, 8'h42); chk_oe("R1 not latched", 0);
    step(1, 1, 1, 0, 8'h42);
  endtask

  task automatic t_writes();
    idle();
    step(0, 1, 0, 0, 8'h00);
    step(0, 0, 0, 0, 8'h81); chk_oe("R6 early write", 0);
    step(0, 0, 1, 0, 8'h82); chk_oe("R6 early write we high", 0);
    step(0, 1, 1, 0, 8'h00);
    step(1, 1, 1, 0, 8'h00);
    idle();
    step(0, 1, 1, 0, 8'h00);
    step(0, 0, 1, 1, 8'h90); chk_oe("R6 late write oe high", 0);
    step(0, 0, 1, 0, 8'h91); chk_drv("R6 late write oe low", 8'h91);
    step(0, 0, 0, 0, 8'h92); chk_oe("R5 we low", 0);
    step(0, 1, 1, 0, 8'h00);
    step(1, 1, 1, 0, 8'h00);
  endtask

  task automatic t_page_refresh();
    idle();
    step(0, 1, 1, 0, 8'h00);
    step(0, 0, 1, 0, 8'hC1); chk_drv("R7 page 1", 8'hC1);
    step(0, 1, 1, 0, 8'hC1); chk_oe("R7 page gap", 0);
    step(0, 0, 1, 0, 8'hC2); chk_drv("R7 page 2", 8'hC2);
    step(0, 1, 1, 0, 8'h00);
    step(1, 1, 1, 0, 8'h00);
    step(0, 1, 1, 0, 8'h00); chk_oe("R7 ras-only refresh", 0);
    step(0, 1, 1, 0, 8'h00); chk_oe("R7 ras-only refresh hold", 0);
    step(1, 1, 1, 0, 8'h00);
    step(1, 0, 1, 0, 8'hD0); chk_oe("R3 cas-only", 0);
    step(1, 0, 1, 0, 8'hD1); chk_oe("R3 cas-only level", 0);
    // column-first refresh from high-impedance
    step(0, 0, 1, 0, 8'hD2); chk_oe("R8 cbr from hiz", 0);
    step(1, 0, 1, 0, 8'hD3); chk_oe("R8 cbr end hiz", 0);
    step(1, 1, 1, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_hold();
    t_no_hold();
    t_writes();
    t_page_refresh();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule